// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides which of eight interrupt request lines should be presented to the processor next. It takes the pending-request vector, the mask vector and the in-service vector from the surrounding controller. Each cycle it reports whether a new interrupt must be raised and which line wins. Priority is not fixed. The search for the best line starts at a movable rotation base and wraps around the eight lines. A line wins only if it strictly outranks every line that is already being serviced. Two operating modes change which in-service lines take part in that comparison: special mask mode and special fully nested mode.

The rotation base is the only state in the block. Three strobes move it. The first is an explicit command that names the line to become lowest priority. The second is a rotating end-of-interrupt, which demotes the highest-ranked in-service line. The third is an acknowledge-time rotation used with automatic end-of-interrupt, which demotes the current winner. Everything else is combinational, so the winner and the interrupt pin follow the inputs in the same cycle.

Top module: `prio_resolver`

## Requirements
- R1: After reset the rotation base is 0, so line 0 has the best rank and line 7 the worst.
- R2: The candidate set is the pending vector ANDed with the inverted mask vector. When `req_valid_o` is 1, `req_line_o` always names a candidate line.
- R3: A line's rank is its distance from the rotation base going upward and wrapping modulo 8. Rank 0 belongs to the line equal to the base. The winner is the candidate with the smallest rank, and `req_line_o` equals (rank + base) mod 8.
- R4: An empty vector has rank 8. When the candidate set is empty, `req_valid_o` is 0 and `req_line_o` is 0.
- R5: `req_valid_o` is 1 only when the candidate rank is strictly smaller than the rank of the effective in-service vector, which uses the same base. When `req_valid_o` is 0, `req_line_o` is 0.
- R6: When `spec_mask_i` is 1, in-service lines that are masked are dropped from the effective in-service vector. When it is 0, all in-service lines count.
- R7: When `spec_nest_i` and `is_master_i` are both 1, the cascade input line 2 is dropped from the effective in-service vector. In every other mode combination, line 2 counts like any other line.
- R8: `int_o` equals `req_valid_o` in every cycle.
- R9: A cycle with `rot_set_i` = 1 loads the base with (`rot_line_i` + 1) mod 8 at the next clock edge.
- R10: A cycle with `rot_eoi_i` = 1 loads the base with (L + 1) mod 8. L is the best-ranked line of the raw in-service vector, with no mode filtering. If that vector is empty, the base is unchanged.
- R11: A cycle with `rot_ack_i` = 1 loads the base with (`req_line_o` + 1) mod 8 when `req_valid_o` is 1, and leaves it unchanged otherwise.
- R12: When several strobes are high in the same cycle, `rot_set_i` takes precedence over `rot_eoi_i`, and `rot_eoi_i` takes precedence over `rot_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | 8 | Pending request vector |
| mask_i | input | 8 | Mask vector, 1 = line masked |
| insvc_i | input | 8 | In-service vector |
| spec_mask_i | input | 1 | Special mask mode enable |
| spec_nest_i | input | 1 | Special fully nested mode enable |
| is_master_i | input | 1 | 1 when this controller is the master of a cascade |
| rot_set_i | input | 1 | Explicit rotation strobe |
| rot_line_i | input | 3 | Line to become lowest priority on `rot_set_i` |
| rot_eoi_i | input | 1 | Rotate on end-of-interrupt strobe |
| rot_ack_i | input | 1 | Rotate on acknowledge strobe |
| req_valid_o | output | 1 | A new interrupt should be raised |
| req_line_o | output | 3 | Winning line number |
| int_o | output | 1 | Interrupt output pin level |
| rot_base_o | output | 3 | Current rotation base |

## Verification
The hardest case to reach from the ports is an in-service line whose rank sits between two candidates. That case needs a shifted base, a filtering mode and a particular mask pattern all at once. Line 2 on a master in special fully nested mode is the sharpest instance of it. The stimulus therefore walks the base through all eight values with the explicit rotation strobe. For each base it then applies every pending pattern under each of the eight mode combinations. The mask and in-service vectors are derived from the pattern index so that sparse and overlapping in-service sets appear under every base.

// File: rtl/prio_pkg.sv
package prio_pkg;

  // Mode flags that select which in-service lines take part in ranking
  typedef struct packed {
    logic spec_mask;
    logic spec_nest;
    logic is_master;
  } prio_mode_t;

  // Source that moved the rotation base, for visibility in assertions
  typedef enum logic [1:0] {
    ROT_HOLD = 2'd0,
    ROT_CMD  = 2'd1,
    ROT_EOI  = 2'd2,
    ROT_ACK  = 2'd3
  } rot_src_e;

endpackage

// File: rtl/prio_rank_find.sv
module prio_rank_find #(
  parameter int unsigned N_LINES = 8,
  localparam int unsigned LW = $clog2(N_LINES),
  localparam int unsigned RW = LW + 1
) (
  input  logic [N_LINES-1:0] vec_i,
  input  logic [LW-1:0]      base_i,
  output logic [RW-1:0]      rank_o
);

  logic [N_LINES-1:0] rotated;

  // Wrap an index that may exceed the line count by less than N_LINES
  function automatic int unsigned wrap_idx(input int unsigned a);
    return (a >= N_LINES) ? a - N_LINES : a;
  endfunction

  // rotated[k] is the line whose rank would be k
  always_comb begin
    rotated = '0;
    for (int unsigned k = 0; k < N_LINES; k++) begin
      rotated[k] = vec_i[wrap_idx(int'(base_i) + k)];
    end
  end

  // First set position in rotated order; N_LINES when empty
  always_comb begin
    logic found;
    found  = 1'b0;
    rank_o = RW'(N_LINES);
    for (int unsigned k = 0; k < N_LINES; k++) begin
      if (!found && rotated[k]) begin
        rank_o = RW'(k);
        found  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/prio_svc_filter.sv
module prio_svc_filter
  import prio_pkg::*;
#(
  parameter int unsigned N_LINES  = 8,
  parameter int unsigned CASC_IDX = 2
) (
  input  logic [N_LINES-1:0] insvc_i,
  input  logic [N_LINES-1:0] mask_i,
  input  prio_mode_t         mode_i,
  output logic [N_LINES-1:0] svc_eff_o
);

  logic drop_casc;
  assign drop_casc = mode_i.spec_nest & mode_i.is_master;

  for (genvar g = 0; g < N_LINES; g++) begin : g_bit
    logic masked_out;
    logic casc_out;
    assign masked_out = mode_i.spec_mask & mask_i[g];
    if (g == CASC_IDX) begin : g_casc
      assign casc_out = drop_casc;
    end else begin : g_plain
      assign casc_out = 1'b0;
    end
    assign svc_eff_o[g] = insvc_i[g] & ~masked_out & ~casc_out;
  end

endmodule

// File: rtl/prio_rot_base.sv
module prio_rot_base
  import prio_pkg::*;
#(
  parameter int unsigned N_LINES = 8,
  localparam int unsigned LW = $clog2(N_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic [LW-1:0] set_line_i,
  input  logic          eoi_i,
  input  logic          eoi_ok_i,
  input  logic [LW-1:0] eoi_line_i,
  input  logic          ack_i,
  input  logic          ack_ok_i,
  input  logic [LW-1:0] ack_line_i,
  output rot_src_e      src_o,
  output logic [LW-1:0] base_o
);

  logic [LW-1:0] base_q;
  logic [LW-1:0] pick_line;

  // The named line becomes lowest priority: base is one past it
  function automatic logic [LW-1:0] after(input logic [LW-1:0] l);
    return (int'(l) == N_LINES - 1) ? '0 : l + LW'(1);
  endfunction

  always_comb begin
    src_o     = ROT_HOLD;
    pick_line = set_line_i;
    if (set_i) begin
      src_o     = ROT_CMD;
      pick_line = set_line_i;
    end else if (eoi_i && eoi_ok_i) begin
      src_o     = ROT_EOI;
      pick_line = eoi_line_i;
    end else if (!eoi_i && ack_i && ack_ok_i) begin
      src_o     = ROT_ACK;
      pick_line = ack_line_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (src_o != ROT_HOLD) begin
      base_q <= after(pick_line);
    end
  end

  assign base_o = base_q;

endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_pkg::*;
#(
  parameter int unsigned N_LINES  = 8,
  parameter int unsigned CASC_IDX = 2,
  localparam int unsigned LW = $clog2(N_LINES),
  localparam int unsigned RW = LW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pend_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic [N_LINES-1:0] insvc_i,
  input  logic               spec_mask_i,
  input  logic               spec_nest_i,
  input  logic               is_master_i,
  input  logic               rot_set_i,
  input  logic [LW-1:0]      rot_line_i,
  input  logic               rot_eoi_i,
  input  logic               rot_ack_i,
  output logic               req_valid_o,
  output logic [LW-1:0]      req_line_o,
  output logic               int_o,
  output logic [LW-1:0]      rot_base_o
);

  // Named internal events, visible to the bound checker
  prio_mode_t         mode;
  logic [N_LINES-1:0] cand_vec;
  logic [N_LINES-1:0] svc_eff;
  logic [RW-1:0]      cand_rank;
  logic [RW-1:0]      svc_rank;
  logic [RW-1:0]      raw_rank;
  logic               cand_any;
  logic               raw_any;
  logic               outranks;
  logic [LW-1:0]      win_line;
  logic [LW-1:0]      eoi_line;
  logic [LW-1:0]      base;
  rot_src_e           rot_src;

  // Map a rank back to a line number for the present base
  function automatic logic [LW-1:0] line_of(input logic [RW-1:0] r,
                                            input logic [LW-1:0] b);
    int unsigned s;
    s = int'(r[LW-1:0]) + int'(b);
    if (s >= N_LINES) s = s - N_LINES;
    return LW'(s);
  endfunction

  assign mode     = '{spec_mask: spec_mask_i, spec_nest: spec_nest_i,
                      is_master: is_master_i};
  assign cand_vec = pend_i & ~mask_i;

  prio_svc_filter #(.N_LINES(N_LINES), .CASC_IDX(CASC_IDX)) u_filter (
    .insvc_i   (insvc_i),
    .mask_i    (mask_i),
    .mode_i    (mode),
    .svc_eff_o (svc_eff)
  );

  prio_rank_find #(.N_LINES(N_LINES)) u_cand_rank (
    .vec_i  (cand_vec),
    .base_i (base),
    .rank_o (cand_rank)
  );

  prio_rank_find #(.N_LINES(N_LINES)) u_svc_rank (
    .vec_i  (svc_eff),
    .base_i (base),
    .rank_o (svc_rank)
  );

  prio_rank_find #(.N_LINES(N_LINES)) u_raw_rank (
    .vec_i  (insvc_i),
    .base_i (base),
    .rank_o (raw_rank)
  );

  assign cand_any = (cand_rank != RW'(N_LINES));
  assign raw_any  = (raw_rank != RW'(N_LINES));
  assign outranks = cand_any && (cand_rank < svc_rank);
  assign win_line = outranks ? line_of(cand_rank, base) : '0;
  assign eoi_line = line_of(raw_rank, base);

  prio_rot_base #(.N_LINES(N_LINES)) u_base (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (rot_set_i),
    .set_line_i (rot_line_i),
    .eoi_i      (rot_eoi_i),
    .eoi_ok_i   (raw_any),
    .eoi_line_i (eoi_line),
    .ack_i      (rot_ack_i),
    .ack_ok_i   (outranks),
    .ack_line_i (win_line),
    .src_o      (rot_src),
    .base_o     (base)
  );

  assign req_valid_o = outranks;
  assign req_line_o  = win_line;
  assign int_o       = outranks;
  assign rot_base_o  = base;

endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
  parameter int unsigned N_LINES = 8,
  localparam int unsigned LW = $clog2(N_LINES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] pend_i,
  input logic [N_LINES-1:0] mask_i,
  input logic [N_LINES-1:0] insvc_i,
  input logic               spec_mask_i,
  input logic               spec_nest_i,
  input logic               rot_set_i,
  input logic [LW-1:0]      rot_line_i,
  input logic               rot_eoi_i,
  input logic               rot_ack_i,
  input logic               req_valid_o,
  input logic [LW-1:0]      req_line_o,
  input logic               int_o,
  input logic [LW-1:0]      rot_base_o
);

  function automatic logic [LW-1:0] nxt(input logic [LW-1:0] l);
    return (int'(l) == N_LINES - 1) ? '0 : l + LW'(1);
  endfunction

  AST_WIN_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (pend_i[req_line_o] && !mask_i[req_line_o])); // R2

  AST_EMPTY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_i & ~mask_i) == '0) |-> (!req_valid_o && req_line_o == '0)); // R4

  AST_WIN_NOT_IN_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !spec_mask_i && !spec_nest_i) |-> !insvc_i[req_line_o]); // R5

  AST_PIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    int_o == req_valid_o); // R8

  AST_CMD_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    rot_set_i |=> rot_base_o == nxt($past(rot_line_i))); // R9

  AST_ACK_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_ack_i && !rot_set_i && !rot_eoi_i && req_valid_o)
      |=> rot_base_o == nxt($past(req_line_o))); // R11

  AST_BASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rot_set_i && !rot_eoi_i && !rot_ack_i) |=> $stable(rot_base_o)); // R12

endmodule

bind prio_resolver prio_resolver_chk #(.N_LINES(N_LINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pend_i      (pend_i),
  .mask_i      (mask_i),
  .insvc_i     (insvc_i),
  .spec_mask_i (spec_mask_i),
  .spec_nest_i (spec_nest_i),
  .rot_set_i   (rot_set_i),
  .rot_line_i  (rot_line_i),
  .rot_eoi_i   (rot_eoi_i),
  .rot_ack_i   (rot_ack_i),
  .req_valid_o (req_valid_o),
  .req_line_o  (req_line_o),
  .int_o       (int_o),
  .rot_base_o  (rot_base_o)
);

// File: tb/sim_prio_resolver.sv
module sim_prio_resolver;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pend = '0, mask = '0, insvc = '0;
  logic       smm = 1'b0, sfn = 1'b0, mst = 1'b0;
  logic       rset = 1'b0, reoi = 1'b0, rack = 1'b0;
  logic [2:0] rline = '0;
  logic       valid, intp;
  logic [2:0] line, base;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  prio_resolver u0 (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask), .insvc_i(insvc),
    .spec_mask_i(smm), .spec_nest_i(sfn), .is_master_i(mst),
    .rot_set_i(rset), .rot_line_i(rline), .rot_eoi_i(reoi), .rot_ack_i(rack),
    .req_valid_o(valid), .req_line_o(line), .int_o(intp), .rot_base_o(base)
  );

  // Reference: count steps from the base until a set bit is met
  function automatic int ref_rank(input logic [7:0] v, input int b);
    for (int k = 0; k < 8; k++) if (v[(b + k) % 8]) return k;
    return 8;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected winner for the current inputs and a known base
  task automatic check_comb(input int b);
    logic [7:0] cand, eff;
    int cr, sr, ev, el;
    cand = pend & ~mask;
    eff  = insvc;
    if (smm) eff = eff & ~mask;                 // R6
    if (sfn && mst) eff[2] = 1'b0;              // R7
    cr = ref_rank(cand, b);
    sr = ref_rank(eff, b);
    ev = (cr < 8 && cr < sr) ? 1 : 0;           // R4 R5
    el = ev ? (cr + b) % 8 : 0;                 // R3
    check("R5 valid", int'(valid), ev);
    check("R3 line", int'(line), el);
    check("R8 pin", int'(intp), ev);
  endtask

  task automatic pulse(input logic s, input logic e, input logic a);
    @(negedge clk);
    rset = s; reoi = e; rack = a;
    @(negedge clk);
    rset = 1'b0; reoi = 1'b0; rack = 1'b0;
  endtask

  task automatic set_base(input int b);
    @(negedge clk);
    rline = 3'((b + 7) % 8);
    pulse(1'b1, 1'b0, 1'b0);
    check("R9 base load", int'(base), b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset base", int'(base), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 base after release", int'(base), 0);
    check("R4 idle valid", int'(valid), 0);
    check("R4 idle line", int'(line), 0);

    // Sweep: every base, every mode combination, every pending pattern
    for (int b = 0; b < 8; b++) begin
      set_base(b);
      for (int m = 0; m < 8; m++) begin
        {smm, sfn, mst} = 3'(m);
        for (int p = 0; p < 256; p++) begin
          pend  = 8'(p);
          mask  = 8'((p * 37 + b * 11) & (p * 13 + m * 29 + 5));
          insvc = 8'((1 << ((p + m) % 8)) | (((p >> 3) & 1) ? (1 << ((b + 2) % 8)) : 0));
          if ((p & 7) == 6) insvc = 8'h04;
          #1;
          check_comb(b);
        end
      end
    end
    {smm, sfn, mst} = 3'b000;

    // R7 corner: line 2 in service, only on master with nesting it is skipped
    set_base(0);
    pend = 8'h08; mask = 8'h00; insvc = 8'h04;
    sfn = 1'b1; mst = 1'b1; #1;
    check("R7 master nested valid", int'(valid), 1);
    check("R7 master nested line", int'(line), 3);
    mst = 1'b0; #1;
    check("R7 slave counts line2", int'(valid), 0);
    sfn = 1'b0; mst = 1'b0;

    // R6 corner: masked in-service line only ignored in special mask mode
    pend = 8'h20; mask = 8'h02; insvc = 8'h02; smm = 1'b1; #1;
    check("R6 special mask valid", int'(valid), 1);
    smm = 1'b0; #1;
    check("R6 normal blocks", int'(valid), 0);

    // R11: acknowledge rotation demotes the winner
    set_base(0);
    pend = 8'h50; mask = 8'h00; insvc = 8'h00;
    pulse(1'b0, 1'b0, 1'b1);
    check("R11 ack rotate", int'(base), 5);
    pend = 8'h00;
    pulse(1'b0, 1'b0, 1'b1);
    check("R11 ack no winner holds", int'(base), 5);

    // R10: end-of-interrupt rotation uses raw in-service, ignoring modes
    insvc = 8'h84; sfn = 1'b1; mst = 1'b1;
    pulse(1'b0, 1'b1, 1'b0);
    check("R10 eoi rotate", int'(base), 0);
    sfn = 1'b0; mst = 1'b0;
    insvc = 8'h00;
    pulse(1'b0, 1'b1, 1'b0);
    check("R10 eoi empty holds", int'(base), 0);

    // R12: precedence among strobes
    pend = 8'h02; insvc = 8'h40; rline = 3'd3;
    pulse(1'b1, 1'b1, 1'b1);
    check("R12 set wins", int'(base), 4);
    pulse(1'b0, 1'b1, 1'b1);
    check("R12 eoi over ack", int'(base), 7);
    insvc = 8'h00; pend = 8'h01;
    pulse(1'b0, 1'b1, 1'b1);
    check("R12 eoi empty blocks ack", int'(base), 7);

    // R2: masked pending line never wins
    set_base(0);
    pend = 8'h01; mask = 8'h01; #1;
    check("R2 masked ignored", int'(valid), 0);
    check("R2 masked line", int'(line), 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule